// File: doc/BRIEF.md
# Payload Check-Value Generator for a Chirp-Radio Frame

This block produces the 16-bit check value that follows the payload of a chirp spread-spectrum radio frame. Payload bytes arrive one per clock with a valid strobe, a flag marking the first byte and a flag marking the final byte. A global enable qualifies every beat. A byte counts as accepted only when both the enable and the valid strobe are high.

The value is the remainder of the payload divided by the generator x^16+x^12+x^5+1 (0x1021). The payload is read as one long bit string: bytes in arrival order, each byte most significant bit first. Unlike a conventional CRC, the dividend is not multiplied by x^16 before division. Because of this, the first bytes pass straight into the register, which acts as a seed. The result is presented as two bytes in transmit order: the low-order remainder byte goes out first and the high-order byte second.

One cycle after the final byte is accepted, a one-cycle done pulse marks the new result. A first-byte flag discards whatever was accumulated before, so frames may follow each other with no idle cycle between them. Whitening, the header's check-present decision and frame assembly belong to neighbouring blocks.

Top module: `payload_chk_gen`

## Requirements
- R1: While reset is asserted and after its release, before any frame completes, `done` is 0 and both check bytes are 0x00.
- R2: A payload of one byte b gives `chk_first` = b and `chk_second` = 0x00.
- R3: For any payload, {`chk_second`,`chk_first`} equals the remainder of the payload bit string modulo 0x1021. The bit string is formed from the bytes in arrival order, each byte MSB first, with no x^16 pre-multiplication and an all-zero starting register.
- R4: When all payload bytes except the last two are zero, `chk_first` equals the last byte and `chk_second` equals the byte before it.
- R5: `done` is high for exactly the one cycle after each accepted byte that has `in_last` set, and is low otherwise.
- R6: A beat with `in_valid` low or `en` low leaves the result unchanged, whatever its data and flags.
- R7: An accepted byte with `in_start` set begins a new frame and discards all bytes accepted before it. This holds in the cycle directly after a final byte, and also in the middle of an unfinished frame.
- R8: `chk_first` and `chk_second` change only in the cycle in which `done` is high, and hold their value between done pulses.
- R9: Payloads of every length from 1 to 255 bytes give the R3 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; a beat is accepted only when high |
| in_valid | input | 1 | Byte strobe |
| in_start | input | 1 | Marks the first byte of a payload |
| in_last | input | 1 | Marks the final byte of a payload |
| in_data | input | 8 | Payload byte |
| chk_first | output | 8 | Check byte sent first (remainder bits 7:0) |
| chk_second | output | 8 | Check byte sent second (remainder bits 15:8) |
| done | output | 1 | One-cycle pulse when a new check value is presented |

## Verification
The bench focuses on the cases where this divider departs from a conventional CRC. For a one-byte payload, a design that pre-multiplies by x^16, or seeds the register with ones, does not return the byte itself. When only the last two bytes are nonzero, a design that does not swap the output bytes returns them in the wrong order. The bench also sends back-to-back frames and restarts a frame partway through. A design that fails to reseed on the first-byte flag leaks the earlier frame into the result. The bench interleaves disabled and invalid beats that carry garbage, which a design that ignores the qualifiers folds into the remainder. Finally, a full 255-byte payload exposes reduction errors that short frames never reach.

// File: rtl/payload_chk_pkg.sv
package payload_chk_pkg;
  localparam int unsigned BYTE_W = 8;

  // Unaugmented division step: each data bit enters the low end of the
  // register, and the generator is folded in when a one leaves the top.
  function automatic logic [15:0] div_byte(input logic [15:0] rem_in,
                                           input logic [7:0]  data_in,
                                           input logic [15:0] gen);
    logic [15:0] r;
    logic        top;
    r = rem_in;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      top = r[15];
      r   = {r[14:0], data_in[i]};
      if (top) r = r ^ gen;
    end
    return r;
  endfunction
endpackage

// File: rtl/chk_div_step.sv
module chk_div_step #(
  parameter int unsigned        REM_W  = 16,
  parameter int unsigned        DATA_W = 8,
  parameter logic [REM_W-1:0]   GEN    = 16'h1021
) (
  input  logic [REM_W-1:0]  rem_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [REM_W-1:0]  rem_out
);
  logic [REM_W-1:0] stage [DATA_W+1];

  assign stage[0] = rem_in;

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : g_bit
      localparam int unsigned SRC = DATA_W - 1 - g;
      logic [REM_W-1:0] shifted;
      assign shifted      = {stage[g][REM_W-2:0], data_in[SRC]};
      assign stage[g + 1] = stage[g][REM_W-1] ? (shifted ^ GEN) : shifted;
    end
  endgenerate

  assign rem_out = stage[DATA_W];
endmodule

// File: rtl/chk_accum.sv
module chk_accum #(
  parameter int unsigned      REM_W  = 16,
  parameter int unsigned      DATA_W = 8,
  parameter logic [REM_W-1:0] GEN    = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  input  logic [DATA_W-1:0] data_in,
  output logic [REM_W-1:0]  rem_next
);
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_d;
  logic [REM_W-1:0] seed;

  // A first byte starts from an empty register, with no idle cycle needed.
  assign seed = restart ? '0 : rem_q;

  chk_div_step #(.REM_W(REM_W), .DATA_W(DATA_W), .GEN(GEN)) u_step (
    .rem_in  (seed),
    .data_in (data_in),
    .rem_out (rem_next)
  );

  always_comb begin
    rem_d = rem_q;
    if (take) rem_d = rem_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end
endmodule

// File: rtl/chk_emit.sv
module chk_emit #(
  parameter int unsigned REM_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [REM_W-1:0]  rem_in,
  output logic [BYTE_W-1:0] first_byte,
  output logic [BYTE_W-1:0] second_byte,
  output logic              done
);
  logic [REM_W-1:0] out_q, out_d;
  logic             done_q, done_d;

  always_comb begin
    out_d  = out_q;
    done_d = fire;
    if (fire) out_d = rem_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      done_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      done_q <= done_d;
    end
  end

  // Transmit order is the reverse of the remainder's significance.
  assign first_byte  = out_q[BYTE_W-1:0];
  assign second_byte = out_q[2*BYTE_W-1:BYTE_W];
  assign done        = done_q;
endmodule

// File: rtl/payload_chk_gen.sv
module payload_chk_gen #(
  parameter int unsigned      DATA_W = 8,
  parameter int unsigned      REM_W  = 16,
  parameter logic [REM_W-1:0] GEN    = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] chk_first,
  output logic [DATA_W-1:0] chk_second,
  output logic              done
);
  logic             take;
  logic [REM_W-1:0] rem_next;

  assign take = en & in_valid;

  chk_accum #(.REM_W(REM_W), .DATA_W(DATA_W), .GEN(GEN)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .restart  (in_start),
    .data_in  (in_data),
    .rem_next (rem_next)
  );

  chk_emit #(.REM_W(REM_W), .BYTE_W(DATA_W)) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (take & in_last),
    .rem_in      (rem_next),
    .first_byte  (chk_first),
    .second_byte (chk_second),
    .done        (done)
  );
endmodule

// File: rtl/payload_chk_gen_checker.sv
module payload_chk_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       in_valid,
  input logic       in_start,
  input logic       in_last,
  input logic [7:0] in_data,
  input logic [7:0] chk_first,
  input logic [7:0] chk_second,
  input logic       done
);
  always_comb begin
    if (rst_n == 1'b0) begin
      p_reset_idle_r1: assert (done == 1'b0 && chk_first == 8'h00 && chk_second == 8'h00);
    end
  end

  p_done_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(en && in_valid && in_last));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(chk_first) && $stable(chk_second)));

  p_single_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid && in_start && in_last) |=>
      (chk_second == 8'h00 && chk_first == $past(in_data)));

  p_idle_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && in_valid) |=> !done);
endmodule

bind payload_chk_gen payload_chk_gen_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .in_valid   (in_valid),
  .in_start   (in_start),
  .in_last    (in_last),
  .in_data    (in_data),
  .chk_first  (chk_first),
  .chk_second (chk_second),
  .done       (done)
);

// File: tb/sim_payload_chk_gen.sv
module sim_payload_chk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, in_valid, in_start, in_last;
  logic [7:0] in_data;
  logic [7:0] chk_first, chk_second;
  logic       done;

  int checks = 0;
  int errors = 0;
  logic [7:0] pay [256];

  always #10 clk = ~clk;

  payload_chk_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_start(in_start), .in_last(in_last), .in_data(in_data),
    .chk_first(chk_first), .chk_second(chk_second), .done(done)
  );

  function automatic logic [15:0] model(input int n);
    logic [15:0] r = 16'h0000;
    logic        top;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        top = r[15];
        r   = {r[14:0], pay[i][b]};
        if (top) r = r ^ 16'h1021;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    en = 1'b1; in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_data = 8'h00;
  endtask

  // Drive n bytes of pay[], optionally with junk beats between them.
  task automatic push(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      if (junk && i > 0) begin
        @(negedge clk);
        en = 1'b0; in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1; in_data = 8'hA5;
        @(negedge clk);
        en = 1'b1; in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1; in_data = 8'h3C;
      end
      @(negedge clk);
      en = 1'b1; in_valid = 1'b1; in_data = pay[i];
      in_start = (i == 0); in_last = (i == n - 1);
    end
  endtask

  task automatic expect_result(input string req, input logic [15:0] exp);
    @(negedge clk);
    idle();
    check({req, " done"}, {31'd0, done}, 32'd1);
    check({req, " value"}, {16'd0, chk_second, chk_first}, {16'd0, exp});
    @(negedge clk);
    check({req, " done drops R5"}, {31'd0, done}, 32'd0);
    check({req, " hold R8"}, {16'd0, chk_second, chk_first}, {16'd0, exp});
  endtask

  task automatic t_reset();
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 bytes", {16'd0, chk_second, chk_first}, 32'd0);
  endtask

  task automatic t_one_byte();
    pay[0] = 8'hC7;
    push(1, 1'b0);
    expect_result("R2 one byte", 16'h00C7);
  endtask

  task automatic t_last_two();
    for (int i = 0; i < 6; i++) pay[i] = 8'h00;
    pay[6] = 8'h5E; pay[7] = 8'h91;
    push(8, 1'b0);
    expect_result("R4 last two", 16'h5E91);
    check("R4 first is last byte", {24'd0, chk_first}, 32'h91);
  endtask

  task automatic t_patterns();
    for (int i = 0; i < 5; i++) pay[i] = 8'hFF;
    push(5, 1'b0);
    expect_result("R3 ones", model(5));
    for (int i = 0; i < 16; i++) pay[i] = 8'(i * 17 + 3);
    push(16, 1'b0);
    expect_result("R3 ramp", model(16));
  endtask

  task automatic t_qualifiers();
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h80 >> i) ^ 8'h4B;
    push(6, 1'b1);
    expect_result("R6 junk beats", model(6));
  endtask

  task automatic t_back_to_back();
    logic [15:0] exp_a, exp_b;
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
    exp_a = model(3);
    push(3, 1'b0);
    pay[0] = 8'hAB; pay[1] = 8'hCD;
    exp_b = model(2);
    @(negedge clk);
    check("R7 frame A", {16'd0, chk_second, chk_first}, {16'd0, exp_a});
    en = 1'b1; in_valid = 1'b1; in_start = 1'b1; in_last = 1'b0; in_data = 8'hAB;
    @(negedge clk);
    in_start = 1'b0; in_last = 1'b1; in_data = 8'hCD;
    expect_result("R7 back to back", exp_b);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 4; i++) pay[i] = 8'hE0 + 8'(i);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      en = 1'b1; in_valid = 1'b1; in_start = (i == 0); in_last = 1'b0; in_data = pay[i];
    end
    pay[0] = 8'h07; pay[1] = 8'h00; pay[2] = 8'h61;
    push(3, 1'b0);
    expect_result("R7 restart mid frame", model(3));
  endtask

  task automatic t_long();
    logic [7:0] s = 8'h5A;
    for (int i = 0; i < 255; i++) begin
      s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
      pay[i] = s;
    end
    push(255, 1'b0);
    expect_result("R9 255 bytes", model(255));
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_byte();
    t_last_two();
    t_patterns();
    t_qualifiers();
    t_back_to_back();
    t_restart();
    t_long();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule